// File: doc/BRIEF.md
# Single-Outstanding Register Request Bridge

This block turns request packets into 32-bit memory-mapped master accesses for a register space. A request carries a direction (read or write), a byte address, four byte enables, a 32-bit write payload and a tag. Only one access may be in flight at a time. A read returns a completion packet that carries the original tag, a success status and the read data. A write is finished once the master command is taken, and it produces no completion.

A request that arrives while an access is still open breaks the programming model. The bridge does not stall it and does not forward it. A rejected read is answered with a completion that has abort status and zero data. A rejected write is dropped, and a sticky error flag goes high and stays high until reset.

Both packet sides use plain ready/valid handshakes. The master side has wait-state flow control and a read-data-valid strobe.

Top module: `rsb_bridge`

## Requirements
- R1: After reset, `avm_read`, `avm_write`, `cpl_valid` and `err_sticky` are 0 and `req_ready` is 1.
- R2: A request accepted while idle shows up on the master port in the next cycle. `avm_address` equals the request address with bits [1:0] cleared, and byte enables and write data are passed through. `ADDR_W` may be 32 or 64.
- R3: While `avm_waitrequest` is high, the master command and all of its fields stay unchanged.
- R4: A write is finished in the cycle its command is taken with `avm_waitrequest` low. It produces no completion, and a following request starts a new access normally.
- R5: For a read, `avm_readdata` is captured when `avm_readdatavalid` is high. The next cycle presents a completion with the request's tag, status 0 (success) and that data.
- R6: A presented completion keeps its tag, status and data until `cpl_ready` takes it.
- R7: A request accepted while an access is open (from acceptance until the write command is taken or the read completion is handed over) is never forwarded to the master port.
- R8: A rejected read produces a completion with the rejected request's tag, status 1 (abort) and data 0.
- R9: A rejected write produces no completion and sets `err_sticky`, which stays 1 until reset.
- R10: If no completion is being presented and both a read completion and an abort completion are pending, the read completion goes first. `req_ready` is 0 while an abort completion is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write payload |
| req_tag | input | TAG_W | Request tag |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion taken |
| cpl_tag | output | TAG_W | Tag of the answered request |
| cpl_status | output | 1 | 0 success, 1 abort |
| cpl_data | output | 32 | Read data (0 on abort) |
| avm_address | output | ADDR_W | Word-aligned byte address |
| avm_read | output | 1 | Read command |
| avm_write | output | 1 | Write command |
| avm_byteenable | output | 4 | Byte enables |
| avm_writedata | output | 32 | Write data |
| avm_readdata | input | 32 | Read data |
| avm_readdatavalid | input | 1 | Read data strobe |
| avm_waitrequest | input | 1 | Slave stall |
| err_sticky | output | 1 | A write was rejected since reset |

## Verification
The assertions assume the slave never raises `avm_readdatavalid` in the cycle its read command is taken, nor unless a read is waiting for data. They also assume the completion sink may hold `cpl_ready` low for any number of cycles. The stimulus holds to both rules: the read-data strobe is driven only after the bench has seen the read command leave the port, and only for one cycle. Requests are driven only between clock edges, and each is held until the handshake.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_RDATA = 2'd2,
    ST_CPL   = 2'd3
  } rsb_state_e;

  localparam logic STAT_OK    = 1'b0;
  localparam logic STAT_ABORT = 1'b1;

  // Clear the two byte-offset bits of an address given at full width.
  function automatic logic [63:0] word_align(input logic [63:0] a);
    return {a[63:2], 2'b00};
  endfunction
endpackage

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
  import rsb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              busy,
  output logic              start_evt,
  output logic [ADDR_W-1:0] avm_address,
  output logic              avm_read,
  output logic              avm_write,
  output logic [3:0]        avm_byteenable,
  output logic [31:0]       avm_writedata,
  input  logic [31:0]       avm_readdata,
  input  logic              avm_readdatavalid,
  input  logic              avm_waitrequest,
  output logic              rd_valid,
  input  logic              rd_take,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [31:0]       rd_data
);
  rsb_state_e state;
  logic       is_wr;
  logic       cmd_taken;

  assign busy      = (state != ST_IDLE);
  assign start_evt = req_fire && (state == ST_IDLE);
  assign avm_read  = (state == ST_CMD) && !is_wr;
  assign avm_write = (state == ST_CMD) && is_wr;
  assign cmd_taken = (state == ST_CMD) && !avm_waitrequest;
  assign rd_valid  = (state == ST_CPL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      is_wr          <= 1'b0;
      avm_address    <= '0;
      avm_byteenable <= '0;
      avm_writedata  <= '0;
      rd_tag         <= '0;
      rd_data        <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_evt) begin
          state          <= ST_CMD;
          is_wr          <= req_write;
          avm_address    <= ADDR_W'(word_align(64'(req_addr)));
          avm_byteenable <= req_be;
          avm_writedata  <= req_wdata;
          rd_tag         <= req_tag;
        end
        ST_CMD: if (cmd_taken) state <= is_wr ? ST_IDLE : ST_RDATA;
        ST_RDATA: if (avm_readdatavalid) begin
          rd_data <= avm_readdata;
          state   <= ST_CPL;
        end
        ST_CPL: if (rd_take) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_cmd_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({avm_read, avm_write}));

  assert_start_issues_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (avm_read || avm_write));

  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (avm_read || avm_write) |-> (avm_address[1:0] == 2'b00));

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((avm_read || avm_write) && avm_waitrequest) |=>
      ((avm_read || avm_write) && $stable(avm_address) && $stable(avm_writedata)
       && $stable(avm_byteenable) && $stable(avm_write)));

  assert_write_no_cpl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (avm_write && !avm_waitrequest) |=> !rd_valid);
endmodule

// File: rtl/rsb_abort_q.sv
module rsb_abort_q #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rej_fire,
  input  logic             rej_write,
  input  logic [TAG_W-1:0] rej_tag,
  input  logic             pop,
  output logic             full,
  output logic [TAG_W-1:0] tag,
  output logic             err_sticky
);
  logic push_rd;
  logic push_wr;

  assign push_rd = rej_fire && !rej_write;
  assign push_wr = rej_fire && rej_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full       <= 1'b0;
      tag        <= '0;
      err_sticky <= 1'b0;
    end else begin
      if (push_rd) begin
        full <= 1'b1;
        tag  <= rej_tag;
      end else if (pop) begin
        full <= 1'b0;
      end
      if (push_wr) err_sticky <= 1'b1;
    end
  end

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  assert_abort_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (full && $stable(tag)));

  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_rd);
endmodule

// File: rtl/rsb_cpl_mux.sv
module rsb_cpl_mux
  import rsb_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [31:0]      rd_data,
  input  logic             ab_valid,
  input  logic [TAG_W-1:0] ab_tag,
  input  logic             cpl_ready,
  output logic             cpl_valid,
  output logic [TAG_W-1:0] cpl_tag,
  output logic             cpl_status,
  output logic [31:0]      cpl_data,
  output logic             rd_take,
  output logic             ab_take
);
  logic hold_vld;
  logic hold_ab;
  logic sel_ab;

  // Keep the presented source while stalled; otherwise reads first.
  assign sel_ab    = hold_vld ? hold_ab : (ab_valid && !rd_valid);
  assign cpl_valid = rd_valid || ab_valid;
  assign cpl_tag   = sel_ab ? ab_tag : rd_tag;
  assign cpl_status = sel_ab ? STAT_ABORT : STAT_OK;
  assign cpl_data  = sel_ab ? 32'd0 : rd_data;
  assign rd_take   = cpl_valid && cpl_ready && !sel_ab;
  assign ab_take   = cpl_valid && cpl_ready && sel_ab;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_ab  <= 1'b0;
    end else begin
      hold_vld <= cpl_valid && !cpl_ready;
      hold_ab  <= sel_ab;
    end
  end

  assert_one_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_take, ab_take}));

  assert_cpl_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=>
      (cpl_valid && $stable(cpl_tag) && $stable(cpl_status) && $stable(cpl_data)));
endmodule

// File: rtl/rsb_bridge.sv
module rsb_bridge
  import rsb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic              cpl_status,
  output logic [31:0]       cpl_data,
  output logic [ADDR_W-1:0] avm_address,
  output logic              avm_read,
  output logic              avm_write,
  output logic [3:0]        avm_byteenable,
  output logic [31:0]       avm_writedata,
  input  logic [31:0]       avm_readdata,
  input  logic              avm_readdatavalid,
  input  logic              avm_waitrequest,
  output logic              err_sticky
);
  logic             req_fire, rej_fire, busy, start_evt;
  logic             rd_valid, rd_take, ab_full, ab_take;
  logic [TAG_W-1:0] rd_tag, ab_tag;
  logic [31:0]      rd_data;

  assign req_ready = !ab_full;
  assign req_fire  = req_valid && req_ready;
  assign rej_fire  = req_fire && busy;

  rsb_ctrl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_tag(req_tag), .busy(busy), .start_evt(start_evt),
    .avm_address(avm_address), .avm_read(avm_read), .avm_write(avm_write),
    .avm_byteenable(avm_byteenable), .avm_writedata(avm_writedata),
    .avm_readdata(avm_readdata), .avm_readdatavalid(avm_readdatavalid),
    .avm_waitrequest(avm_waitrequest), .rd_valid(rd_valid), .rd_take(rd_take),
    .rd_tag(rd_tag), .rd_data(rd_data)
  );

  rsb_abort_q #(.TAG_W(TAG_W)) u_abort (
    .clk(clk), .rst_n(rst_n), .rej_fire(rej_fire), .rej_write(req_write),
    .rej_tag(req_tag), .pop(ab_take), .full(ab_full), .tag(ab_tag),
    .err_sticky(err_sticky)
  );

  rsb_cpl_mux #(.TAG_W(TAG_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_tag(rd_tag),
    .rd_data(rd_data), .ab_valid(ab_full), .ab_tag(ab_tag),
    .cpl_ready(cpl_ready), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .cpl_status(cpl_status), .cpl_data(cpl_data), .rd_take(rd_take),
    .ab_take(ab_take)
  );

  assert_reject_not_forwarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_fire && !(avm_read || avm_write)) |=> !(avm_read || avm_write));

  assert_abort_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_status == STAT_ABORT) |-> (cpl_data == 32'd0));
endmodule

// File: tb/rsb_bridge_test.sv
module rsb_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [TW-1:0] req_tag = '0;
  logic req_ready, cpl_valid, cpl_status, avm_read, avm_write, err_sticky;
  logic cpl_ready = 0;
  logic [TW-1:0] cpl_tag;
  logic [31:0] cpl_data, avm_writedata;
  logic [AW-1:0] avm_address;
  logic [3:0] avm_byteenable;
  logic [31:0] avm_readdata = '0;
  logic avm_readdatavalid = 0, avm_waitrequest = 0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsb_bridge #(.ADDR_W(AW), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .req_tag(req_tag), .cpl_valid(cpl_valid),
    .cpl_ready(cpl_ready), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
    .cpl_data(cpl_data), .avm_address(avm_address), .avm_read(avm_read),
    .avm_write(avm_write), .avm_byteenable(avm_byteenable),
    .avm_writedata(avm_writedata), .avm_readdata(avm_readdata),
    .avm_readdatavalid(avm_readdatavalid), .avm_waitrequest(avm_waitrequest),
    .err_sticky(err_sticky)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] aligned(input logic [31:0] a);
    return a & 32'hFFFF_FFFC;
  endfunction

  // Drive at a falling edge, hold until taken, return at the falling edge after.
  task automatic send(input logic wr, input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] d, input logic [TW-1:0] t);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d; req_tag = t;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 avm_read", avm_read, 0);
    chk("R1 avm_write", avm_write, 0);
    chk("R1 cpl_valid", cpl_valid, 0);
    chk("R1 err_sticky", err_sticky, 0);
    chk("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_write_wait();
    avm_waitrequest = 1;
    send(1, 32'h0000_1003, 4'b0110, 32'hCAFE_0001, 8'h11);
    chk("R2 write cmd", avm_write, 1);
    chk("R2 addr", avm_address, aligned(32'h0000_1003));
    chk("R2 be", avm_byteenable, 4'b0110);
    chk("R2 wdata", avm_writedata, 32'hCAFE_0001);
    repeat (2) @(negedge clk);
    chk("R3 held write", avm_write, 1);
    chk("R3 held addr", avm_address, 32'h0000_1000);
    avm_waitrequest = 0;
    @(negedge clk);
    chk("R4 write done", avm_write, 0);
    chk("R4 no cpl", cpl_valid, 0);
    @(negedge clk);
    chk("R4 still no cpl", cpl_valid, 0);
  endtask

  task automatic t_read();
    send(0, 32'h0000_2006, 4'hF, 32'h0, 8'h5A);
    chk("R4 next access starts", avm_read, 1);
    chk("R2 read addr", avm_address, 32'h0000_2004);
    @(negedge clk);
    chk("R5 read taken", avm_read, 0);
    avm_readdatavalid = 1; avm_readdata = 32'hDEAD_BEEF;
    @(negedge clk);
    avm_readdatavalid = 0;
    chk("R5 cpl valid", cpl_valid, 1);
    chk("R5 cpl tag", cpl_tag, 8'h5A);
    chk("R5 cpl status", cpl_status, 0);
    chk("R5 cpl data", cpl_data, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    chk("R6 held valid", cpl_valid, 1);
    chk("R6 held data", cpl_data, 32'hDEAD_BEEF);
    cpl_ready = 1;
    @(negedge clk);
    cpl_ready = 0;
    chk("R6 taken", cpl_valid, 0);
  endtask

  task automatic t_abort_read();
    avm_waitrequest = 1;
    send(0, 32'h0000_3000, 4'hF, 32'h0, 8'h01);
    send(0, 32'h0000_9008, 4'hF, 32'h0, 8'h02);
    chk("R7 addr unchanged", avm_address, 32'h0000_3000);
    chk("R7 still first read", avm_read, 1);
    chk("R8 abort valid", cpl_valid, 1);
    chk("R8 abort tag", cpl_tag, 8'h02);
    chk("R8 abort status", cpl_status, 1);
    chk("R8 abort data", cpl_data, 32'h0);
    cpl_ready = 1;
    @(negedge clk);
    cpl_ready = 0;
    chk("R8 drained", cpl_valid, 0);
    avm_waitrequest = 0;
    @(negedge clk);
    avm_readdatavalid = 1; avm_readdata = 32'h1234_5678;
    @(negedge clk);
    avm_readdatavalid = 0;
    chk("R5 first tag", cpl_tag, 8'h01);
    chk("R5 first status", cpl_status, 0);
    chk("R5 first data", cpl_data, 32'h1234_5678);
    cpl_ready = 1;
    @(negedge clk);
    cpl_ready = 0;
    chk("R7 no extra command", avm_read | avm_write, 0);
  endtask

  task automatic t_abort_write();
    send(0, 32'h0000_4000, 4'hF, 32'h0, 8'h03);
    @(negedge clk);
    send(1, 32'h0000_5000, 4'hF, 32'hBAD0_BAD0, 8'h33);
    chk("R9 err set", err_sticky, 1);
    chk("R9 no cpl", cpl_valid, 0);
    chk("R7 write not forwarded", avm_write, 0);
    avm_readdatavalid = 1; avm_readdata = 32'h0000_00A5;
    @(negedge clk);
    avm_readdatavalid = 0;
    chk("R5 after reject tag", cpl_tag, 8'h03);
    cpl_ready = 1;
    @(negedge clk);
    cpl_ready = 0;
    chk("R9 err stays", err_sticky, 1);
  endtask

  task automatic t_both_pending();
    send(0, 32'h0000_6000, 4'hF, 32'h0, 8'h04);
    @(negedge clk);
    avm_readdatavalid = 1; avm_readdata = 32'h0000_0444;
    @(negedge clk);
    avm_readdatavalid = 0;
    send(0, 32'h0000_7000, 4'hF, 32'h0, 8'h05);
    chk("R10 read first", cpl_tag, 8'h04);
    chk("R10 read status", cpl_status, 0);
    chk("R10 ready low", req_ready, 0);
    cpl_ready = 1;
    @(negedge clk);
    chk("R10 abort next", cpl_tag, 8'h05);
    chk("R10 abort status", cpl_status, 1);
    @(negedge clk);
    cpl_ready = 0;
    chk("R10 drained", cpl_valid, 0);
    chk("R10 ready back", req_ready, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_write_wait();
    t_read();
    t_abort_read();
    t_abort_write();
    t_both_pending();
    do_reset();
    chk("R9 cleared by reset", err_sticky, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1..: actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule